// File: doc/BRIEF.md
# Link Mode Resolution Controller

This block holds the speed and duplex configuration of a 10/100 Ethernet PHY. When reset is released it loads the local ability set from two strap pins. It holds a small management register set, and from those registers and the link partner's ability word it settles the operating speed and duplex. With negotiation enabled, the mode is the best ability that both ends offer, taken when the negotiation-done strobe arrives. With negotiation disabled, two control bits set the mode directly.

A state machine drives the outputs. It has four states. `S_FORCED` means negotiation is off and the control bits drive the mode. `S_WAIT` means negotiation is on and the block waits for a done strobe. `S_DONE` means a common ability was found and the mode is latched. `S_FAIL` means the last done strobe found no common ability. The transitions are:
- `to_forced`: taken from any state when the enable bit is clear.
- `arm`: `S_FORCED` to `S_WAIT` when the enable bit is set.
- `resolve_ok`: `S_WAIT`, `S_DONE` or `S_FAIL` to `S_DONE` on a done strobe with a common ability.
- `resolve_none`: the same source states to `S_FAIL` on a done strobe with no common ability.
- `restart`: `S_DONE` or `S_FAIL` back to `S_WAIT`. In those two states a restart takes priority over a done strobe in the same cycle.

Partner abilities come from a received code word. They can also come from a parallel-detect event, which loads a fixed code for a 100 Mb/s or a 10 Mb/s partner.

Top module: `link_mode_ctrl`

## Requirements
- R1: When reset is released, the advertisement register (address 0x04) reads `0x0001` with its ability bits [8:5] taken from the strap pins. The bit meanings are: bit 5 is 10 half, bit 6 is 10 full, bit 7 is 100 half, bit 8 is 100 full. The strap values decode as follows:
  - strap 00 gives bits 5 and 6.
  - strap 01 gives bits 7 and 8.
  - strap 10 gives bits 5 and 7.
  - strap 11 gives all four bits.
- R2: With negotiation enabled, a done strobe selects the highest-priority ability set in both the advertisement and partner registers. The order from highest to lowest is 100 full, 100 half, 10 full, 10 half. The outputs show the result (`op_speed100`, `op_full_duplex`) with `res_valid`=1 and `neg_complete`=1, one cycle after the strobe.
- R3: When control bit 12 (negotiation enable) is clear, the outputs follow control bit 13 (speed, 1 = 100 Mb/s) and bit 8 (duplex, 1 = full), with `res_valid`=1 and `neg_complete`=0.
- R4: While negotiation is enabled, writing control bits 13 and 8 does not change the outputs.
- R5: Writing control bit 9 (restart) with bit 12 set clears `neg_complete`. Bit 9 reads back 0 after one cycle.
- R6: A done strobe with no common ability drives `res_valid` low and leaves the speed and duplex outputs at their previous values.
- R7: A parallel-detect event loads the partner register (0x05) with `0x0081` for a 100 Mb/s partner and with `0x0021` for a 10 Mb/s partner.
- R8: The status register (0x01) reads these bits:
  - bits [15:11] read `01111`.
  - bit 6 reads 1.
  - bit 3 reads 1.
  - bit 0 reads 1.
  - bit 5 mirrors `neg_complete`.
  - bit 2 mirrors `link_up`.
- R9: The PHY status register (0x10) reports:
  - bit 0 = link.
  - bit 1 = 10 Mb/s.
  - bit 2 = full duplex.
  - bit 4 = negotiation complete.

  Bits 1 and 2 read 0 while the link is down.
- R10: A register write is visible from the clock edge that samples the write strobe. Reads of unmapped addresses return `0x0000`.
- R11: Software can clear advertisement bits, and resolution uses the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_an | input | 2 | Strap pins, sampled during reset |
| mg_we | input | 1 | Management write strobe |
| mg_addr | input | 5 | Management register address |
| mg_wdata | input | 16 | Management write data |
| mg_rdata | output | 16 | Management read data (combinational) |
| partner_word | input | 16 | Received partner ability code word |
| partner_load | input | 1 | Load `partner_word` into the partner register |
| pdet_valid | input | 1 | Parallel-detect event |
| pdet_fast | input | 1 | Parallel-detected partner is 100 Mb/s |
| neg_done | input | 1 | Negotiation-done strobe |
| link_up | input | 1 | Valid link indication |
| op_speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| op_full_duplex | output | 1 | Resolved duplex, 1 = full |
| res_valid | output | 1 | Resolved mode is valid |
| neg_complete | output | 1 | Negotiation complete |

## Verification
A wrong state shows up as a wrong pair of `res_valid`/`neg_complete` in the cycle after the done strobe, restart write or enable write that should have moved the state. A latched mode that is stale or was wrongly overwritten shows on the speed and duplex outputs from the first cycle after a failed resolution. A corrupted advertisement or partner register shows up at the ports only at the next done strobe, so the bench follows every load with a strobe and also reads both registers back.

// File: rtl/lmr_pkg.sv
`timescale 1ns/1ps
package lmr_pkg;

    localparam int LMR_AW = 5;
    localparam int LMR_DW = 16;
    localparam int ABIL_LO = 5;
    localparam int ABIL_N  = 4;

    localparam logic [LMR_AW-1:0] A_CTRL  = 5'h00;
    localparam logic [LMR_AW-1:0] A_STAT  = 5'h01;
    localparam logic [LMR_AW-1:0] A_ADV   = 5'h04;
    localparam logic [LMR_AW-1:0] A_PART  = 5'h05;
    localparam logic [LMR_AW-1:0] A_PHYST = 5'h10;

    typedef enum logic [1:0] {
        S_FORCED = 2'd0,
        S_WAIT   = 2'd1,
        S_DONE   = 2'd2,
        S_FAIL   = 2'd3
    } lmr_state_e;

    typedef struct packed {
        logic spd100;
        logic full;
    } lmr_mode_t;

    // ability nibble order: {100 full, 100 half, 10 full, 10 half}
    function automatic logic [ABIL_N-1:0] strap_abil(input logic [1:0] s);
        logic [ABIL_N-1:0] r;
        unique case (s)
            2'b00:   r = 4'b0011;
            2'b01:   r = 4'b1100;
            2'b10:   r = 4'b0101;
            default: r = 4'b1111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lmr_resolver.sv
`timescale 1ns/1ps
module lmr_resolver
    import lmr_pkg::*;
#(
    parameter int N = ABIL_N
) (
    input  logic [N-1:0] loc_abil,
    input  logic [N-1:0] par_abil,
    output logic         match,
    output lmr_mode_t    best
);
    logic [N-1:0] common;
    assign common = loc_abil & par_abil;

    // ascending scan: the last hit is the highest priority
    always_comb begin
        best  = '0;
        match = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (common[i]) begin
                match       = 1'b1;
                best.spd100 = (i >= 2);
                best.full   = i[0];
            end
        end
    end
endmodule

// File: rtl/lmr_regs.sv
`timescale 1ns/1ps
module lmr_regs
    import lmr_pkg::*;
#(
    parameter int AW = LMR_AW,
    parameter int DW = LMR_DW,
    parameter logic [DW-1:0] PD_FAST_CODE = 16'h0081,
    parameter logic [DW-1:0] PD_SLOW_CODE = 16'h0021
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_an,
    input  logic          mg_we,
    input  logic [AW-1:0] mg_addr,
    input  logic [DW-1:0] mg_wdata,
    output logic [DW-1:0] mg_rdata,
    input  logic [DW-1:0] partner_word,
    input  logic          partner_load,
    input  logic          pdet_valid,
    input  logic          pdet_fast,
    input  logic          neg_complete,
    input  logic          link_up,
    input  logic          cur_speed100,
    input  logic          cur_full,
    output logic          an_en,
    output logic          ctrl_speed,
    output logic          ctrl_dup,
    output logic          restart_q,
    output logic [DW-1:0] adv_q,
    output logic [DW-1:0] part_q
);
    localparam int BIT_SPD = 13;
    localparam int BIT_EN  = 12;
    localparam int BIT_RST = 9;
    localparam int BIT_DUP = 8;

    logic wr_ctrl, wr_adv;
    assign wr_ctrl = mg_we && (mg_addr == A_CTRL);
    assign wr_adv  = mg_we && (mg_addr == A_ADV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            an_en      <= 1'b1;
            ctrl_speed <= 1'b0;
            ctrl_dup   <= 1'b0;
            restart_q  <= 1'b0;
        end else if (wr_ctrl) begin
            an_en      <= mg_wdata[BIT_EN];
            ctrl_speed <= mg_wdata[BIT_SPD];
            ctrl_dup   <= mg_wdata[BIT_DUP];
            restart_q  <= mg_wdata[BIT_RST];
        end else begin
            restart_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= '0;
            adv_q[0] <= 1'b1;
            adv_q[ABIL_LO +: ABIL_N] <= strap_abil(strap_an);
        end else if (wr_adv) begin
            adv_q <= mg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (pdet_valid) begin
            part_q <= pdet_fast ? PD_FAST_CODE : PD_SLOW_CODE;
        end else if (partner_load) begin
            part_q <= partner_word;
        end
    end

    logic [DW-1:0] ctrl_word, stat_word, phy_word;

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[BIT_SPD] = ctrl_speed;
        ctrl_word[BIT_EN]  = an_en;
        ctrl_word[BIT_RST] = restart_q;
        ctrl_word[BIT_DUP] = ctrl_dup;

        stat_word          = '0;
        stat_word[14:11]   = 4'b1111;
        stat_word[6]       = 1'b1;
        stat_word[5]       = neg_complete;
        stat_word[4]       = part_q[13];
        stat_word[3]       = 1'b1;
        stat_word[2]       = link_up;
        stat_word[0]       = 1'b1;

        phy_word           = '0;
        phy_word[0]        = link_up;
        phy_word[1]        = link_up & ~cur_speed100;
        phy_word[2]        = link_up & cur_full;
        phy_word[4]        = neg_complete;
    end

    always_comb begin
        unique case (mg_addr)
            A_CTRL:  mg_rdata = ctrl_word;
            A_STAT:  mg_rdata = stat_word;
            A_ADV:   mg_rdata = adv_q;
            A_PART:  mg_rdata = part_q;
            A_PHYST: mg_rdata = phy_word;
            default: mg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/link_mode_ctrl.sv
`timescale 1ns/1ps
module link_mode_ctrl
    import lmr_pkg::*;
#(
    parameter int AW = LMR_AW,
    parameter int DW = LMR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_an,
    input  logic          mg_we,
    input  logic [AW-1:0] mg_addr,
    input  logic [DW-1:0] mg_wdata,
    output logic [DW-1:0] mg_rdata,
    input  logic [DW-1:0] partner_word,
    input  logic          partner_load,
    input  logic          pdet_valid,
    input  logic          pdet_fast,
    input  logic          neg_done,
    input  logic          link_up,
    output logic          op_speed100,
    output logic          op_full_duplex,
    output logic          res_valid,
    output logic          neg_complete
);
    logic          an_en, ctrl_speed, ctrl_dup, restart_q;
    logic [DW-1:0] adv_q, part_q;
    logic          match;
    lmr_mode_t     best, mode_q;
    lmr_state_e    state_q, state_d;

    lmr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_an(strap_an),
        .mg_we(mg_we), .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
        .partner_word(partner_word), .partner_load(partner_load),
        .pdet_valid(pdet_valid), .pdet_fast(pdet_fast),
        .neg_complete(neg_complete), .link_up(link_up),
        .cur_speed100(op_speed100), .cur_full(op_full_duplex),
        .an_en(an_en), .ctrl_speed(ctrl_speed), .ctrl_dup(ctrl_dup),
        .restart_q(restart_q), .adv_q(adv_q), .part_q(part_q)
    );

    lmr_resolver #(.N(ABIL_N)) u_res (
        .loc_abil(adv_q[ABIL_LO +: ABIL_N]),
        .par_abil(part_q[ABIL_LO +: ABIL_N]),
        .match(match),
        .best(best)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!an_en) begin
            state_d = S_FORCED;                               // to_forced
        end else begin
            unique case (state_q)
                S_FORCED: state_d = S_WAIT;                   // arm
                S_WAIT:   if (neg_done) state_d = match ? S_DONE : S_FAIL;
                S_DONE, S_FAIL: begin
                    if (restart_q)     state_d = S_WAIT;      // restart
                    else if (neg_done) state_d = match ? S_DONE : S_FAIL;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    // latched mode: only a successful resolution updates it
    always_ff @(posedge clk) begin
        if (!rst_n)                                      mode_q <= '0;
        else if (state_d == S_DONE && neg_done && an_en && state_q != S_FORCED)
                                                         mode_q <= best;
    end

    // outputs
    always_comb begin
        op_speed100    = mode_q.spd100;
        op_full_duplex = mode_q.full;
        res_valid      = 1'b0;
        neg_complete   = 1'b0;
        unique case (state_q)
            S_FORCED: begin
                op_speed100    = ctrl_speed;
                op_full_duplex = ctrl_dup;
                res_valid      = 1'b1;
            end
            S_WAIT: ;
            S_DONE: begin
                res_valid    = 1'b1;
                neg_complete = 1'b1;
            end
            S_FAIL: neg_complete = 1'b1;
        endcase
    end
endmodule

// File: rtl/lmr_checker.sv
`timescale 1ns/1ps
module lmr_checker #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mg_we,
    input logic [AW-1:0] mg_addr,
    input logic [DW-1:0] mg_wdata,
    input logic [DW-1:0] mg_rdata,
    input logic          pdet_valid,
    input logic          pdet_fast,
    input logic          an_en,
    input logic          ctrl_speed,
    input logic          ctrl_dup,
    input logic [DW-1:0] part_q,
    input logic          op_speed100,
    input logic          op_full_duplex,
    input logic          res_valid,
    input logic          neg_complete
);
    a_r3_forced_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!an_en && $past(!an_en)) |->
            (op_speed100 == ctrl_speed && op_full_duplex == ctrl_dup && res_valid && !neg_complete));

    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_we && mg_addr == '0 && mg_wdata[9] && mg_wdata[12]) |=> ##1 !neg_complete);

    a_r6_hold_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(!res_valid)) |-> ($stable(op_speed100) && $stable(op_full_duplex)));

    a_r7_pdet_code: assert property (@(posedge clk) disable iff (!rst_n)
        pdet_valid |=> (part_q == ($past(pdet_fast) ? 16'h0081 : 16'h0021)));

    a_r8_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_addr == 5'h01) |-> (mg_rdata[15:11] == 5'b01111 && mg_rdata[6] && mg_rdata[3] && mg_rdata[0]));
endmodule

bind link_mode_ctrl lmr_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mg_we(mg_we), .mg_addr(mg_addr),
    .mg_wdata(mg_wdata), .mg_rdata(mg_rdata),
    .pdet_valid(pdet_valid), .pdet_fast(pdet_fast),
    .an_en(an_en), .ctrl_speed(ctrl_speed), .ctrl_dup(ctrl_dup), .part_q(part_q),
    .op_speed100(op_speed100), .op_full_duplex(op_full_duplex),
    .res_valid(res_valid), .neg_complete(neg_complete)
);

// File: tb/sim_link_mode_ctrl.sv
`timescale 1ns/1ps
module sim_link_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_an = 2'b00;
    logic        mg_we = 1'b0;
    logic [4:0]  mg_addr = '0;
    logic [15:0] mg_wdata = '0;
    logic [15:0] mg_rdata;
    logic [15:0] partner_word = '0;
    logic        partner_load = 1'b0;
    logic        pdet_valid = 1'b0;
    logic        pdet_fast = 1'b0;
    logic        neg_done = 1'b0;
    logic        link_up = 1'b0;
    logic        op_speed100, op_full_duplex, res_valid, neg_complete;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [1:0] prev_mode;

    always #2.5 clk = ~clk;

    link_mode_ctrl u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); mg_we = 1'b1; mg_addr = a; mg_wdata = d;
        @(negedge clk); mg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        mg_addr = a; #0.5; d = mg_rdata;
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk); rst_n = 1'b0; strap_an = s;
        tick(3); rst_n = 1'b1; prev_mode = 2'b00;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); neg_done = 1'b1;
        @(negedge clk); neg_done = 1'b0;
    endtask

    task automatic load_partner(input logic [15:0] w);
        @(negedge clk); partner_word = w; partner_load = 1'b1;
        @(negedge clk); partner_load = 1'b0;
    endtask

    // {valid, speed100, full}
    function automatic logic [2:0] exp_res(input logic [3:0] a, input logic [3:0] p);
        logic [3:0] c = a & p;
        if (c[3]) return 3'b111;
        if (c[2]) return 3'b110;
        if (c[1]) return 3'b101;
        if (c[0]) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] exp_strap(input logic [1:0] s);
        case (s)
            2'b00: return 4'b0011;
            2'b01: return 4'b1100;
            2'b10: return 4'b0101;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic negotiate(input logic [3:0] a, input logic [3:0] p, input string req);
        logic [2:0] e;
        wr(5'h00, 16'h1200);
        wr(5'h04, {7'b0, a, 4'b0, 1'b1});
        load_partner({7'b0, p, 5'b00001});
        pulse_done();
        e = exp_res(a, p);
        if (e[2]) prev_mode = e[1:0];
        chk({req, " res_valid"}, {15'b0, res_valid}, {15'b0, e[2]});
        chk({req, " mode"}, {14'b0, op_speed100, op_full_duplex}, {14'b0, prev_mode});
        chk({req, " complete"}, {15'b0, neg_complete}, 16'h0001);
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        tick(2);

        // R1: strap decode into advertisement register
        for (int s = 0; s < 4; s++) begin
            do_reset(s[1:0]);
            rd(5'h04, d);
            chk("R1 strap adv", d, {7'b0, exp_strap(s[1:0]), 4'b0, 1'b1});
        end

        // reset state of outputs
        chk("R2 reset res_valid/complete", {14'b0, res_valid, neg_complete}, 16'h0000);

        // R8: status fixed bits, R10: unmapped reads
        rd(5'h01, d); chk("R8 status fixed", d & 16'hF849, 16'h7849);
        rd(5'h02, d); chk("R10 unmapped 0x02", d, 16'h0000);
        rd(5'h1F, d); chk("R10 unmapped 0x1F", d, 16'h0000);

        // R2: directed priority cases
        negotiate(4'b1111, 4'b1111, "R2 all");
        negotiate(4'b0111, 4'b1111, "R2 no100F");
        negotiate(4'b0011, 4'b1011, "R2 10F");
        negotiate(4'b0001, 4'b1111, "R2 10H");

        // R6: no common ability keeps mode, invalid
        negotiate(4'b1100, 4'b0011, "R6 nomatch");

        // R10: write visible right after the sampling edge
        wr(5'h04, 16'h01E1);
        rd(5'h04, d); chk("R10 write visible", d, 16'h01E1);

        // R5: restart clears complete; bit self-clears
        negotiate(4'b1111, 4'b0100, "R5 pre");
        wr(5'h00, 16'h1200);
        tick(1);
        chk("R5 complete cleared", {15'b0, neg_complete}, 16'h0000);
        rd(5'h00, d); chk("R5 restart self-clear", d & 16'h0200, 16'h0000);

        // R4: forced bits ignored when enabled
        pulse_done();
        wr(5'h00, 16'h1000 | (prev_mode[1] ? 16'h0000 : 16'h2000) | (prev_mode[0] ? 16'h0000 : 16'h0100));
        tick(2);
        chk("R4 forced bits ignored", {14'b0, op_speed100, op_full_duplex}, {14'b0, prev_mode});
        chk("R4 still valid", {15'b0, res_valid}, 16'h0001);

        // R3: forced mode
        wr(5'h00, 16'h2100); tick(2);
        chk("R3 forced 100F", {13'b0, res_valid, op_speed100, op_full_duplex}, 16'h0007);
        chk("R3 forced complete low", {15'b0, neg_complete}, 16'h0000);
        wr(5'h00, 16'h0000); tick(2);
        chk("R3 forced 10H", {13'b0, res_valid, op_speed100, op_full_duplex}, 16'h0004);

        // R9: PHY status gated by link
        link_up = 1'b0; rd(5'h10, d); chk("R9 link down", d & 16'h0007, 16'h0000);
        link_up = 1'b1; rd(5'h10, d); chk("R9 link up 10H", d & 16'h0007, 16'h0003);
        wr(5'h00, 16'h2100); tick(2);
        rd(5'h10, d); chk("R9 link up 100F", d & 16'h0007, 16'h0005);

        // R7: parallel detection codes
        @(negedge clk); pdet_valid = 1'b1; pdet_fast = 1'b1;
        @(negedge clk); pdet_valid = 1'b0;
        rd(5'h05, d); chk("R7 pdet fast", d, 16'h0081);
        @(negedge clk); pdet_valid = 1'b1; pdet_fast = 1'b0;
        @(negedge clk); pdet_valid = 1'b0;
        rd(5'h05, d); chk("R7 pdet slow", d, 16'h0021);
        wr(5'h00, 16'h1000); tick(1);
        wr(5'h04, 16'h01E1);
        pulse_done();
        chk("R7 pdet resolves 10H", {13'b0, res_valid, op_speed100, op_full_duplex}, 16'h0004);
        prev_mode = 2'b00;

        // R11 / R2 / R6: constrained random mixes
        for (int i = 0; i < 40; i++) begin
            logic [3:0] a, p;
            a = 4'($urandom());
            p = 4'($urandom());
            negotiate(a, p, "R11 random");
            rd(5'h04, d); chk("R11 adv readback", d, {7'b0, a, 4'b0, 1'b1});
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule